// File: doc/BRIEF.md
# Reset and Boot Sequencer

This block brings a small processor core out of reset in a controlled order. It tells apart a cold start, which begins with the power-on indication and must let the clock generator's phase-locked loop settle, from a warm reset issued while the clock is already stable. While the core is held, the block drives three clear strobes: one empties every stack pointer, one masks every interrupt, and one clears the mode/status register. Warm reset pulses that are too short to be meant are filtered out.

When reset is released, the sequencer picks the next step. If an external bus master is asking for the bus, it waits. Once the bus is free, a boot strap chooses between starting a byte-wide boot loader and going straight to execution. The boot loader receives a 22-bit byte address made of a page byte, which is meant to be driven on the data lines as upper address bits, and a 14-bit offset. When execution starts, a one-cycle fetch strobe presents the reset vector. A separate registered enable gates the clock output pin from a disable control bit.

Top module: `rst_boot_seq`

## Requirements
- R1: After `por_n` rises, the core stays held (strobes high, `core_run` and `boot_busy` low) for at least LOCK_CYCLES clock cycles, and for no more than LOCK_CYCLES+3 when `rst_in_n` is released together with `por_n`. If `rst_in_n` is held low past that point, the core leaves reset 4 cycles after `rst_in_n` rises.
- R2: After power-up, a warm reset with `rst_in_n` low for MIN_PULSE-2 or more cycles asserts the strobes 5 cycles after `rst_in_n` falls. The core resumes 3 cycles after `rst_in_n` rises, with no lock wait.
- R3: A warm reset with `rst_in_n` low for fewer than MIN_PULSE-2 cycles is ignored. The strobes stay low and the core keeps running. The pulse is measured after the two-stage synchronizer, which stretches it by two cycles.
- R4: `stk_clr`, `irq_mask_all` and `stat_clr` are all high whenever the core is held and all low otherwise. `por_n` low forces them high at once.
- R5: On release with `bus_req` low, `boot_mode` high starts the boot loader (`boot_busy` high, `core_run` low). `boot_mode` low goes straight to execution.
- R6: If `bus_req` is high at release, neither boot nor execution starts and the strobes are low. The choice is made when `bus_req` drops, using `boot_mode` as it is at that time.
- R7: `boot_busy` stays high until `boot_done` is seen, and execution starts on the next cycle. While `boot_busy` is high, `boot_page` and `boot_offs` carry BOOT_BASE bits 21:14 and 13:0. Otherwise both are zero.
- R8: `core_run` is high only while executing. In the first cycle of execution `fetch_vld` is high for exactly one cycle, with `fetch_addr` = RESET_VECTOR (default 0x0000). Otherwise `fetch_addr` is zero.
- R9: `clkout_en` is high while the core is held. Otherwise it equals the inverse of `clkout_dis` as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Power-on indication, asynchronous, active low; starts a cold sequence |
| rst_in_n | input | 1 | External reset request, asynchronous, active low |
| boot_mode | input | 1 | Boot strap: 1 loads code through the boot loader |
| bus_req | input | 1 | External bus request pending |
| boot_done | input | 1 | Boot loader finished |
| clkout_dis | input | 1 | Control bit that disables the clock output |
| stk_clr | output | 1 | Set all stack pointers to empty |
| irq_mask_all | output | 1 | Mask all interrupts |
| stat_clr | output | 1 | Clear the mode/status register |
| core_run | output | 1 | Core executing |
| boot_busy | output | 1 | Boot loader running |
| boot_page | output | BOOT_PAGE_W | Upper byte-address bits for the boot loader |
| boot_offs | output | BOOT_OFFS_W | Lower byte-address bits for the boot loader |
| fetch_vld | output | 1 | First-fetch strobe |
| fetch_addr | output | PC_W | First-fetch address |
| clkout_en | output | 1 | Enable for the clock output pin |

## Verification
The bench measures how long the first cold hold lasts. A sequencer that counted lock cycles from reset release, or that compared against the wrong limit, would release early or late and land outside the allowed window. It probes the warm filter on both sides of its threshold: a filter off by one would either swallow a three-cycle pulse or act on a two-cycle glitch. It holds the bus request across a release and then changes the boot strap in the same cycle the request drops. A design that latched the strap at release would boot instead of running. Finally, it keeps `clkout_dis` set through a warm reset, so an enable that is not forced on while held shows up as a mismatch.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  localparam int SEQ_ST_N = 6;

  // one-hot sequencer states
  typedef enum logic [SEQ_ST_N-1:0] {
    ST_COLD_HOLD  = 6'b000001,
    ST_LOCK_WAIT  = 6'b000010,
    ST_RST_ACTIVE = 6'b000100,
    ST_BUS_WAIT   = 6'b001000,
    ST_BOOT       = 6'b010000,
    ST_RUN        = 6'b100000
  } seq_state_e;

endpackage

// File: rtl/rbs_rst_sync.sv
module rbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] chain_q;

  // assert at once, release after STAGES edges
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_s_n = chain_q[STAGES-1];

endmodule

// File: rtl/rbs_sat_counter.sv
module rbs_sat_counter #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);

  localparam int CNT_W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign at_limit = (cnt_q == CNT_W'(LIMIT));
  assign cnt_en   = clr | (inc & ~at_limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (inc && !at_limit) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  AST_SAT_HOLDS: assert property (@(posedge clk) disable iff (!arst_n)
    (at_limit && !clr) |=> at_limit); // R1

endmodule

// File: rtl/rbs_fsm.sv
module rbs_fsm
  import rbs_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       rst_s_n,
  input  logic       lock_done,
  input  logic       warm_go,
  input  logic       bus_req,
  input  logic       boot_mode,
  input  logic       boot_done,
  output seq_state_e st_q,
  output logic       st_fresh
);

  seq_state_e st_d;
  seq_state_e release_tgt;

  always_comb begin
    if (bus_req) begin
      release_tgt = ST_BUS_WAIT;
    end else if (boot_mode) begin
      release_tgt = ST_BOOT;
    end else begin
      release_tgt = ST_RUN;
    end
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_COLD_HOLD: begin
        if (rst_s_n) st_d = ST_LOCK_WAIT;
      end
      ST_LOCK_WAIT: begin
        if (!rst_s_n)       st_d = ST_COLD_HOLD;
        else if (lock_done) st_d = release_tgt;
      end
      ST_RST_ACTIVE: begin
        if (rst_s_n) st_d = release_tgt;
      end
      ST_BUS_WAIT: begin
        if (warm_go)       st_d = ST_RST_ACTIVE;
        else if (!bus_req) st_d = boot_mode ? ST_BOOT : ST_RUN;
      end
      ST_BOOT: begin
        if (warm_go)        st_d = ST_RST_ACTIVE;
        else if (boot_done) st_d = ST_RUN;
      end
      ST_RUN: begin
        if (warm_go) st_d = ST_RST_ACTIVE;
      end
      default: st_d = ST_COLD_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q     <= ST_COLD_HOLD;
      st_fresh <= 1'b0;
    end else begin
      st_q     <= st_d;
      st_fresh <= (st_d != st_q);
    end
  end

  AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!arst_n)
    $countones(st_q) == 1); // R4

  AST_RUN_AFTER_LOCK: assert property (@(posedge clk) disable iff (!arst_n)
    (st_q == ST_RUN) |-> lock_done); // R1

  AST_BOOT_ENTRY: assert property (@(posedge clk) disable iff (!arst_n)
    (st_q == ST_BOOT && st_fresh) |-> $past(boot_mode && !bus_req)); // R5

  AST_BUS_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!arst_n)
    (st_q == ST_BUS_WAIT && bus_req && rst_s_n) |=> (st_q == ST_BUS_WAIT)); // R6

endmodule

// File: rtl/rbs_out_ctl.sv
module rbs_out_ctl
  import rbs_pkg::*;
#(
  parameter int                            PC_W         = 14,
  parameter logic [PC_W-1:0]               RESET_VECTOR = '0,
  parameter int                            BOOT_PAGE_W  = 8,
  parameter int                            BOOT_OFFS_W  = 14,
  parameter logic [BOOT_PAGE_W+BOOT_OFFS_W-1:0] BOOT_BASE = '0
) (
  input  logic                   clk,
  input  logic                   arst_n,
  input  seq_state_e             st_q,
  input  logic                   st_fresh,
  input  logic                   clkout_dis,
  output logic                   stk_clr,
  output logic                   irq_mask_all,
  output logic                   stat_clr,
  output logic                   core_run,
  output logic                   boot_busy,
  output logic [BOOT_PAGE_W-1:0] boot_page,
  output logic [BOOT_OFFS_W-1:0] boot_offs,
  output logic                   fetch_vld,
  output logic [PC_W-1:0]        fetch_addr,
  output logic                   clkout_en
);

  localparam int BOOT_AW = BOOT_PAGE_W + BOOT_OFFS_W;

  logic hold;
  logic clk_en_q;

  assign hold = (st_q == ST_COLD_HOLD) || (st_q == ST_LOCK_WAIT) ||
                (st_q == ST_RST_ACTIVE);

  assign stk_clr      = hold;
  assign irq_mask_all = hold;
  assign stat_clr     = hold;

  assign core_run  = (st_q == ST_RUN);
  assign boot_busy = (st_q == ST_BOOT);
  assign fetch_vld = core_run & st_fresh;

  assign fetch_addr = fetch_vld ? RESET_VECTOR : '0;
  assign boot_page  = boot_busy ? BOOT_BASE[BOOT_AW-1 -: BOOT_PAGE_W] : '0;
  assign boot_offs  = boot_busy ? BOOT_BASE[BOOT_OFFS_W-1:0] : '0;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      clk_en_q <= 1'b1;
    end else begin
      clk_en_q <= ~clkout_dis;
    end
  end

  assign clkout_en = hold | clk_en_q;

  AST_CLKOUT_TRACKS: assert property (@(posedge clk) disable iff (!arst_n)
    !hold |-> (clkout_en == !$past(clkout_dis))); // R9

  AST_FETCH_ONE_SHOT: assert property (@(posedge clk) disable iff (!arst_n)
    fetch_vld |=> !fetch_vld); // R8

endmodule

// File: rtl/rst_boot_seq.sv
module rst_boot_seq
  import rbs_pkg::*;
#(
  parameter int                            LOCK_CYCLES  = 2000,
  parameter int                            MIN_PULSE    = 5,
  parameter int                            SYNC_STAGES  = 2,
  parameter int                            PC_W         = 14,
  parameter logic [PC_W-1:0]               RESET_VECTOR = '0,
  parameter int                            BOOT_PAGE_W  = 8,
  parameter int                            BOOT_OFFS_W  = 14,
  parameter logic [BOOT_PAGE_W+BOOT_OFFS_W-1:0] BOOT_BASE = '0
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic                   rst_in_n,
  input  logic                   boot_mode,
  input  logic                   bus_req,
  input  logic                   boot_done,
  input  logic                   clkout_dis,
  output logic                   stk_clr,
  output logic                   irq_mask_all,
  output logic                   stat_clr,
  output logic                   core_run,
  output logic                   boot_busy,
  output logic [BOOT_PAGE_W-1:0] boot_page,
  output logic [BOOT_OFFS_W-1:0] boot_offs,
  output logic                   fetch_vld,
  output logic [PC_W-1:0]        fetch_addr,
  output logic                   clkout_en
);

  localparam int LOW_LIMIT = MIN_PULSE - 1;

  logic       sync_arst_n;
  logic       rst_s_n;
  logic       lock_done;
  logic       low_at_limit;
  logic       warm_go;
  logic       in_cold;
  seq_state_e st_q;
  logic       st_fresh;

  assign sync_arst_n = rst_in_n & por_n;

  rbs_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .arst_n  (sync_arst_n),
    .rst_s_n (rst_s_n)
  );

  assign in_cold = (st_q == ST_COLD_HOLD) || (st_q == ST_LOCK_WAIT);

  // lock wait counted from power-on release, never cleared by warm reset
  rbs_sat_counter #(
    .LIMIT (LOCK_CYCLES)
  ) u_lock_cnt (
    .clk      (clk),
    .arst_n   (por_n),
    .clr      (1'b0),
    .inc      (in_cold),
    .at_limit (lock_done)
  );

  // consecutive low cycles of the synchronized reset
  rbs_sat_counter #(
    .LIMIT (LOW_LIMIT)
  ) u_low_cnt (
    .clk      (clk),
    .arst_n   (por_n),
    .clr      (rst_s_n),
    .inc      (~rst_s_n),
    .at_limit (low_at_limit)
  );

  assign warm_go = ~rst_s_n & low_at_limit;

  rbs_fsm u_fsm (
    .clk       (clk),
    .arst_n    (por_n),
    .rst_s_n   (rst_s_n),
    .lock_done (lock_done),
    .warm_go   (warm_go),
    .bus_req   (bus_req),
    .boot_mode (boot_mode),
    .boot_done (boot_done),
    .st_q      (st_q),
    .st_fresh  (st_fresh)
  );

  rbs_out_ctl #(
    .PC_W         (PC_W),
    .RESET_VECTOR (RESET_VECTOR),
    .BOOT_PAGE_W  (BOOT_PAGE_W),
    .BOOT_OFFS_W  (BOOT_OFFS_W),
    .BOOT_BASE    (BOOT_BASE)
  ) u_out (
    .clk          (clk),
    .arst_n       (por_n),
    .st_q         (st_q),
    .st_fresh     (st_fresh),
    .clkout_dis   (clkout_dis),
    .stk_clr      (stk_clr),
    .irq_mask_all (irq_mask_all),
    .stat_clr     (stat_clr),
    .core_run     (core_run),
    .boot_busy    (boot_busy),
    .boot_page    (boot_page),
    .boot_offs    (boot_offs),
    .fetch_vld    (fetch_vld),
    .fetch_addr   (fetch_addr),
    .clkout_en    (clkout_en)
  );

  AST_WARM_NEEDS_WIDTH: assert property (@(posedge clk) disable iff (!por_n)
    (st_q == ST_RST_ACTIVE && st_fresh) |-> $past(!rst_s_n)); // R2

endmodule

// File: tb/test_rst_boot_seq.sv
`timescale 1ns/1ps
module test_rst_boot_seq;

  localparam int          LOCK  = 2000;
  localparam logic [21:0] BBASE = {8'hA5, 14'h0123};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        por_n, rst_in_n, boot_mode, bus_req, boot_done, clkout_dis;
  logic        stk_clr, irq_mask_all, stat_clr, core_run, boot_busy;
  logic        fetch_vld, clkout_en;
  logic [7:0]  boot_page;
  logic [13:0] boot_offs;
  logic [13:0] fetch_addr;
  logic [6:0]  obs;

  rst_boot_seq #(
    .LOCK_CYCLES (LOCK),
    .MIN_PULSE   (5),
    .BOOT_BASE   (BBASE)
  ) i_rst_boot_seq (
    .clk (clk), .por_n (por_n), .rst_in_n (rst_in_n), .boot_mode (boot_mode),
    .bus_req (bus_req), .boot_done (boot_done), .clkout_dis (clkout_dis),
    .stk_clr (stk_clr), .irq_mask_all (irq_mask_all), .stat_clr (stat_clr),
    .core_run (core_run), .boot_busy (boot_busy), .boot_page (boot_page),
    .boot_offs (boot_offs), .fetch_vld (fetch_vld), .fetch_addr (fetch_addr),
    .clkout_en (clkout_en)
  );

  // {stk_clr, irq_mask_all, stat_clr, boot_busy, core_run, fetch_vld, clkout_en}
  assign obs = {stk_clr, irq_mask_all, stat_clr, boot_busy, core_run, fetch_vld, clkout_en};

  localparam logic [6:0] V_HOLD  = 7'b1110001;
  localparam logic [6:0] V_RUN   = 7'b0000101;
  localparam logic [6:0] V_RUN0  = 7'b0000100;
  localparam logic [6:0] V_RUN1  = 7'b0000111;
  localparam logic [6:0] V_BOOT  = 7'b0001001;
  localparam logic [6:0] V_BUSW  = 7'b0000001;

  typedef struct {
    string      req;
    logic [6:0] exp;
  } exp_t;

  exp_t sb_q[$];
  int   n_chk = 0;
  int   n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push(input string req, input logic [6:0] v);
    exp_t e;
    e.req = req;
    e.exp = v;
    sb_q.push_back(e);
  endtask

  // monitor: compares queued expectations 1 ns after each falling edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        chk(e.req, {25'd0, obs}, {25'd0, e.exp});
      end
    end
  end

  task automatic warm_pulse(input int len);
    @(negedge clk);
    rst_in_n = 1'b0;
    repeat (len) @(negedge clk);
    rst_in_n = 1'b1;
  endtask

  // cycles from now until core_run or boot_busy rises
  task automatic poll_start(output int cnt);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      #1;
      cnt++;
      if (core_run || boot_busy) break;
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int held;
    int cnt;
    por_n = 1'b0; rst_in_n = 1'b0; bus_req = 1'b0; boot_mode = 1'b0;
    boot_done = 1'b0; clkout_dis = 1'b0;
    repeat (3) @(negedge clk);
    push("R4 reset state", V_HOLD);

    // R1: cold start, lock wait
    @(negedge clk);
    por_n = 1'b1; rst_in_n = 1'b1;
    held = 0;
    for (int i = 0; i < LOCK + 100; i++) begin
      @(negedge clk);
      #1;
      if (stk_clr) held++;
      else break;
    end
    chk("R1 cold hold window", 32'(held >= LOCK && held <= LOCK + 3), 32'd1);
    chk("R8 first fetch strobe", {31'd0, fetch_vld}, 32'd1);
    chk("R8 first fetch address", {18'd0, fetch_addr}, 32'd0);
    chk("R5 boot skipped", {30'd0, boot_busy, core_run}, 32'd1);
    @(negedge clk); push("R8 fetch one shot", V_RUN);

    // R9: clock output enable follows the disable bit
    @(negedge clk); clkout_dis = 1'b1;
    @(negedge clk); push("R9 clkout off", V_RUN0);
    clkout_dis = 1'b0;
    @(negedge clk); push("R9 clkout on", V_RUN);

    // R3: two-cycle glitch ignored
    @(negedge clk); rst_in_n = 1'b0;
    repeat (2) begin @(negedge clk); push("R3 glitch ignored", V_RUN); end
    rst_in_n = 1'b1;
    repeat (4) begin @(negedge clk); push("R3 glitch ignored", V_RUN); end

    // R2: long warm reset, clock output forced on while held
    @(negedge clk); rst_in_n = 1'b0; clkout_dis = 1'b1;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      if (k <= 4) push("R3 filter delay", V_RUN0);
      else        push("R2 R9 warm hold", V_HOLD);
    end
    rst_in_n = 1'b1;
    poll_start(cnt);
    chk("R2 warm release latency", 32'(cnt), 32'd3);
    chk("R9 clkout after hold", {31'd0, clkout_en}, 32'd0);
    clkout_dis = 1'b0;

    // R5, R7: boot path
    boot_mode = 1'b1;
    warm_pulse(10);
    poll_start(cnt);
    chk("R5 boot start latency", 32'(cnt), 32'd3);
    chk("R5 boot not run", {30'd0, boot_busy, core_run}, 32'd2);
    chk("R7 boot page", {24'd0, boot_page}, 32'hA5);
    chk("R7 boot offset", {18'd0, boot_offs}, 32'h0123);
    repeat (5) begin @(negedge clk); push("R7 boot waits for done", V_BOOT); end
    boot_done = 1'b1;
    @(negedge clk); push("R7 R8 run after boot", V_RUN1);
    boot_done = 1'b0;
    #1;
    chk("R7 boot address idle", {10'd0, boot_page, boot_offs}, 32'd0);

    // R6: bus request at release, strap changes when it drops
    bus_req = 1'b1;
    warm_pulse(10);
    repeat (2) @(negedge clk);
    repeat (5) begin @(negedge clk); push("R6 bus wait", V_BUSW); end
    bus_req = 1'b0; boot_mode = 1'b0;
    @(negedge clk); push("R6 decision on drop", V_RUN1);

    // R2: threshold pulse of three cycles triggers
    @(negedge clk); rst_in_n = 1'b0;
    repeat (3) begin @(negedge clk); push("R2 before filter", V_RUN); end
    rst_in_n = 1'b1;
    @(negedge clk); push("R2 before filter", V_RUN);
    @(negedge clk); push("R2 threshold pulse", V_HOLD);
    @(negedge clk); push("R8 fetch after warm", V_RUN1);

    // R1: second cold start with reset held past lock
    @(negedge clk); por_n = 1'b0; rst_in_n = 1'b0;
    push("R4 por forces hold", V_HOLD);
    @(negedge clk); por_n = 1'b1;
    repeat (LOCK + 500) @(negedge clk);
    push("R1 held while reset low", V_HOLD);
    rst_in_n = 1'b1;
    poll_start(cnt);
    chk("R1 lock already done", 32'(cnt), 32'd4);

    repeat (3) @(negedge clk);
    #2;
    finish_run();
  end

endmodule